// File: doc/BRIEF.md
# Framed Manchester Tag Identifier Decoder

This block takes a serial stream of already-sliced bits, one bit per clock in which `in_valid` is high. It looks for a six-bit start marker, `1,1,1,0,0,0`, at every bit position. The marker is deliberately not a valid Manchester code. After a marker, the bits are taken in pairs, and each pair whose two halves differ becomes one data bit. That bit is shifted into a 96-bit identifier register, which is built as three 32-bit words chained by carries. The first pair whose halves are equal ends the data phase.

A frame is only accepted when a second marker confirms it. The equal pair and the next four bits must again spell the marker. When they do, the identifier, a 16-bit card-number field and the count of decoded bits are latched to the outputs and `frame_valid` pulses for one clock. The confirming marker then serves as the start marker of the following frame.

The block detects markers with a sliding window, so it needs no sample buffer. It is meant to sit behind a demodulator and bit aggregator in a low-frequency tag reader.

Top module: `tagid_frame_decoder`

## Requirements
- R1: After synchronous reset, `frame_valid` is 0 and `tag_id`, `card_num` and `bit_count` are all 0.
- R2: While hunting, the block recognises the marker `1,1,1,0,0,0` (oldest bit first) ending on any accepted bit, whatever bits came before it.
- R3: After a marker, accepted bits form pairs. The pair (1,0) decodes to 0 and (0,1) decodes to 1. Each decoded bit enters `tag_id[0]`, and older bits move toward `tag_id[95]`, so `tag_id` holds the last 96 decoded bits, with bits above the decoded count at 0.
- R4: A pair with equal halves ends the data phase. A report follows only if that pair plus the next four accepted bits equal the marker. Otherwise nothing is reported, the outputs keep their values, and hunting resumes from the bits after that pair.
- R5: A report sets `frame_valid` for exactly one clock. It appears after the clock edge that accepts the last bit of the confirming marker. `tag_id`, `card_num` and `bit_count` stay unchanged until the next report.
- R6: `card_num` equals bits 16 down to 1 of the reported `tag_id`.
- R7: `bit_count` is the number of decoded pairs in the reported frame, and it saturates at 255.
- R8: The confirming marker also starts the next frame. The identifier and the count are cleared at the start of every frame attempt, so no bit of one frame appears in the next one.
- R9: A clock with `in_valid` low changes no decoding state and produces no report, whatever the value on `in_bit`.
- R10: A marker that is directly followed by another marker is reported as a frame with identifier 0 and count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_bit` carries a new stream bit this clock |
| in_bit | input | 1 | Serial stream bit |
| frame_valid | output | 1 | One-clock pulse when a confirmed frame is reported |
| tag_id | output | 96 | Identifier of the last confirmed frame |
| card_num | output | 16 | Bits 16:1 of `tag_id` |
| bit_count | output | 8 | Decoded pairs in the last confirmed frame (saturating) |

## Verification
A wrong phase in the pair tracking shows up at the ports as a flipped or shifted identifier, or as a report that never comes. Such an error appears at the first confirmed frame after the fault, at most about one frame length later. A stale window or a missed clear shows up as a spurious report, or as bits from an earlier frame leaking into the next `tag_id`. The bench therefore chains frames of very different lengths back to back, inserts random gaps between accepted bits, and feeds confirm sequences that fail. It then compares every report, and the absence of a report, against identifiers built from the payloads it sent.

// File: rtl/tagid_pkg.sv
package tagid_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 3;
    localparam int ID_W      = WORD_W * NUM_WORDS;
    localparam int CARD_W    = 16;
    localparam int CARD_LSB  = 1;
    localparam int CNT_W     = 8;
    localparam int MARK_LEN  = 6;
    localparam logic [MARK_LEN-1:0] MARKER = 6'b111000;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_HALF_A  = 2'd1,
        ST_HALF_B  = 2'd2,
        ST_CONFIRM = 2'd3
    } dec_state_t;

    // command from the sequencer to the identifier register
    typedef struct packed {
        logic clear;
        logic shift;
        logic bit_val;
    } id_cmd_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/tagid_marker_window.sv
module tagid_marker_window #(
    parameter int MLEN = tagid_pkg::MARK_LEN,
    parameter logic [MLEN-1:0] PATTERN = tagid_pkg::MARKER
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic match_now
);
    // window of the most recent bits, newest in bit 0; cleared to zero so
    // the leading ones of the marker can only come from real stream bits
    logic [MLEN-1:0] win_q;
    logic [MLEN-1:0] win_next;

    assign win_next  = {win_q[MLEN-2:0], in_bit};
    assign match_now = in_valid && (win_next == PATTERN);

    always_ff @(posedge clk) begin
        if (rst)           win_q <= '0;
        else if (in_valid) win_q <= win_next;
    end

    assert_win_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(win_q));

endmodule

// File: rtl/tagid_shift_id.sv
module tagid_shift_id #(
    parameter int WORD_W    = tagid_pkg::WORD_W,
    parameter int NUM_WORDS = tagid_pkg::NUM_WORDS,
    parameter int CNT_W     = tagid_pkg::CNT_W,
    localparam int ID_W     = WORD_W * NUM_WORDS
) (
    input  logic                clk,
    input  logic                rst,
    input  tagid_pkg::id_cmd_t  cmd,
    output logic [ID_W-1:0]     id_o,
    output logic [CNT_W-1:0]    cnt_o
);
    // one word per stage; the top bit of each word carries into the next
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        logic [WORD_W-1:0] wq;
        logic              carry_in;
        if (k == 0) begin : g_first
            assign carry_in = cmd.bit_val;
        end else begin : g_chain
            assign carry_in = id_o[k*WORD_W-1];
        end
        always_ff @(posedge clk) begin
            if (rst || cmd.clear) wq <= '0;
            else if (cmd.shift)   wq <= {wq[WORD_W-2:0], carry_in};
        end
        assign id_o[k*WORD_W +: WORD_W] = wq;
    end

    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
        if (rst || cmd.clear) cnt_q <= '0;
        else if (cmd.shift)   cnt_q <= tagid_pkg::sat_inc(cnt_q);
    end
    assign cnt_o = cnt_q;

    assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd.shift && !cmd.clear && cnt_q == {CNT_W{1'b1}}) |=> cnt_q == {CNT_W{1'b1}});

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (cnt_q == '0 && id_o == '0));

endmodule

// File: rtl/tagid_frame_ctrl.sv
module tagid_frame_ctrl
    import tagid_pkg::*;
#(
    parameter int MLEN = MARK_LEN,
    localparam int CONF_BITS = MLEN - 2,
    localparam int CONF_W = (CONF_BITS > 1) ? $clog2(CONF_BITS) : 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  logic    in_bit,
    input  logic    match_now,
    output id_cmd_t cmd,
    output logic    report
);
    dec_state_t        state_q, state_d;
    logic              half_q, half_d;
    logic [CONF_W-1:0] conf_q, conf_d;

    always_comb begin
        state_d = state_q;
        half_d  = half_q;
        conf_d  = conf_q;
        cmd     = '0;
        report  = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (match_now) begin
                        cmd.clear = 1'b1;
                        state_d   = ST_HALF_A;
                    end
                end
                ST_HALF_A: begin
                    half_d  = in_bit;
                    state_d = ST_HALF_B;
                end
                ST_HALF_B: begin
                    if (in_bit != half_q) begin
                        cmd.shift   = 1'b1;
                        cmd.bit_val = in_bit;
                        state_d     = ST_HALF_A;
                    end else begin
                        // equal halves: they are the first two bits of a candidate marker
                        conf_d  = '0;
                        state_d = ST_CONFIRM;
                    end
                end
                ST_CONFIRM: begin
                    if (conf_q == CONF_W'(CONF_BITS - 1)) begin
                        cmd.clear = 1'b1;
                        if (match_now) begin
                            report  = 1'b1;
                            state_d = ST_HALF_A;
                        end else begin
                            state_d = ST_HUNT;
                        end
                    end else begin
                        conf_d = conf_q + 1'b1;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            half_q  <= 1'b0;
            conf_q  <= '0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
            conf_q  <= conf_d;
        end
    end

    assert_report_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        report |=> !report);

    assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(state_q) && $stable(half_q) && $stable(conf_q)));

endmodule

// File: rtl/tagid_frame_decoder.sv
module tagid_frame_decoder
    import tagid_pkg::*;
#(
    parameter int P_WORD_W    = WORD_W,
    parameter int P_NUM_WORDS = NUM_WORDS,
    parameter int P_CARD_W    = CARD_W,
    parameter int P_CARD_LSB  = CARD_LSB,
    parameter int P_CNT_W     = CNT_W,
    localparam int P_ID_W     = P_WORD_W * P_NUM_WORDS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_bit,
    output logic                 frame_valid,
    output logic [P_ID_W-1:0]    tag_id,
    output logic [P_CARD_W-1:0]  card_num,
    output logic [P_CNT_W-1:0]   bit_count
);
    logic              match_now;
    logic              report;
    id_cmd_t           cmd;
    logic [P_ID_W-1:0] id_cur;
    logic [P_CNT_W-1:0] cnt_cur;

    tagid_marker_window #(.MLEN(MARK_LEN), .PATTERN(MARKER)) u_window (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .match_now(match_now)
    );

    tagid_frame_ctrl #(.MLEN(MARK_LEN)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .match_now(match_now), .cmd(cmd), .report(report)
    );

    tagid_shift_id #(.WORD_W(P_WORD_W), .NUM_WORDS(P_NUM_WORDS), .CNT_W(P_CNT_W)) u_id (
        .clk(clk), .rst(rst), .cmd(cmd), .id_o(id_cur), .cnt_o(cnt_cur)
    );

    // result registers take the identifier before the clear of the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_valid <= 1'b0;
            tag_id      <= '0;
            card_num    <= '0;
            bit_count   <= '0;
        end else begin
            frame_valid <= report;
            if (report) begin
                tag_id    <= id_cur;
                card_num  <= id_cur[P_CARD_LSB +: P_CARD_W];
                bit_count <= cnt_cur;
            end
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> ($stable(tag_id) && $stable(card_num) && $stable(bit_count)));

    assert_card_field_R6: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> card_num == tag_id[P_CARD_LSB +: P_CARD_W]);

endmodule

// File: tb/test_tagid_frame_decoder.sv
module test_tagid_frame_decoder;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_bit = 1'b0;
    logic        frame_valid;
    logic [95:0] tag_id;
    logic [15:0] card_num;
    logic [7:0]  bit_count;

    int total = 0;
    int bad   = 0;
    logic [95:0] exp_ids[$];
    logic [7:0]  exp_cnts[$];
    logic [95:0] last_id = '0;
    logic        prev_v = 1'b0;
    int          max_gap = 0;

    always #(CLK_P/2) clk = ~clk;

    tagid_frame_decoder i_tagid_frame_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .frame_valid(frame_valid), .tag_id(tag_id), .card_num(card_num),
        .bit_count(bit_count)
    );

    task automatic check(input logic ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] exp_id(input logic [511:0] p, input int len);
        logic [95:0] r = '0;
        for (int i = 0; i < 96; i++) r[i] = (i < len) ? p[i] : 1'b0;
        return r;
    endfunction

    // monitor: every report is compared with the next expected frame
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_valid) begin
                check(!prev_v, "R5 pulse longer than one clock", 96'(prev_v), 96'd0);
                if (exp_ids.size() == 0) begin
                    check(1'b0, "R4 unexpected report", tag_id, 96'd0);
                end else begin
                    logic [95:0] e;
                    logic [7:0]  c;
                    e = exp_ids.pop_front();
                    c = exp_cnts.pop_front();
                    check(tag_id == e, "R3 tag_id", tag_id, e);
                    check(card_num == e[16:1], "R6 card_num", 96'(card_num), 96'(e[16:1]));
                    check(bit_count == c, "R7 bit_count", 96'(bit_count), 96'(c));
                    last_id = e;
                end
            end
            prev_v <= frame_valid;
        end
    end

    // R9: idle clocks with random in_bit between accepted bits
    task automatic send_bit(input logic b);
        int gap;
        gap = (max_gap > 0) ? int'($urandom_range(max_gap, 0)) : 0;
        repeat (gap) begin
            in_valid = 1'b0;
            in_bit   = 1'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_bit   = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_marker();
        send_bit(1); send_bit(1); send_bit(1);
        send_bit(0); send_bit(0); send_bit(0);
    endtask

    task automatic send_data(input logic [511:0] p, input int len);
        for (int i = len - 1; i >= 0; i--) begin
            send_bit(~p[i]);
            send_bit(p[i]);
        end
    endtask

    // equal pair 00 followed by 0101: a failed confirm, back to hunting
    task automatic send_term();
        send_bit(0); send_bit(0); send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    endtask

    // noise starting with 0 and never holding three ones in a row
    task automatic send_noise(input int n);
        int run = 0;
        for (int i = 0; i < n; i++) begin
            logic b;
            b = (i == 0 || run == 2) ? 1'b0 : 1'($urandom);
            run = b ? run + 1 : 0;
            send_bit(b);
        end
    endtask

    function automatic logic [511:0] rand_payload();
        logic [511:0] p;
        for (int w = 0; w < 16; w++) p[w*32 +: 32] = $urandom;
        return p;
    endfunction

    task automatic expect_frame(input logic [511:0] p, input int len);
        exp_ids.push_back(exp_id(p, len));
        exp_cnts.push_back((len > 255) ? 8'd255 : 8'(len));
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired act=%h exp=%h", 96'd0, 96'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [511:0] p, p2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(frame_valid == 1'b0, "R1 frame_valid", 96'(frame_valid), 96'd0);
        check(tag_id == '0, "R1 tag_id", tag_id, 96'd0);
        check(card_num == '0 && bit_count == '0, "R1 card/count", 96'({card_num, bit_count}), 96'd0);

        // R10: marker immediately followed by marker, R2 after noise
        send_noise(9);
        send_marker();
        expect_frame('0, 0);
        send_marker();
        send_term();

        // R8 and R3: long frame then short frame, confirm marker reused
        p  = rand_payload();
        p2 = rand_payload();
        send_marker();
        send_data(p, 100);  expect_frame(p, 100);
        send_marker();
        send_data(p2, 5);   expect_frame(p2, 5);
        send_marker();
        send_term();

        // R7 saturation of the count with 300 decoded bits
        p = rand_payload();
        send_marker();
        send_data(p, 300);  expect_frame(p, 300);
        send_marker();
        send_term();
        @(negedge clk);
        check(exp_ids.size() == 0, "R7 saturating frame reported", 96'(exp_ids.size()), 96'd0);

        // R4: equal pair 11 followed by 0100 is not a marker, no report, outputs held
        p = rand_payload();
        send_marker();
        send_data(p, 20);
        send_bit(1); send_bit(1); send_bit(0); send_bit(1); send_bit(0); send_bit(0);
        send_noise(12);
        check(tag_id == last_id, "R4 outputs held after failed confirm", tag_id, last_id);
        check(bit_count == 8'd255, "R5 bit_count held", 96'(bit_count), 96'd255);

        // random frames mixed with gaps on in_valid
        max_gap = 2;
        for (int it = 0; it < 30; it++) begin
            int nfr;
            send_noise(int'($urandom_range(20, 0)));
            send_marker();
            nfr = int'($urandom_range(3, 1));
            for (int f = 0; f < nfr; f++) begin
                int len;
                len = ($urandom_range(9, 0) == 0) ? int'($urandom_range(300, 96)) : int'($urandom_range(110, 0));
                p = rand_payload();
                send_data(p, len);
                expect_frame(p, len);
                send_marker();
            end
            if ($urandom_range(1, 0) == 1) begin
                p = rand_payload();
                send_data(p, int'($urandom_range(40, 1)));
            end
            send_term();
        end
        max_gap = 0;
        repeat (3) @(negedge clk);
        check(exp_ids.size() == 0, "R2 all expected frames reported", 96'(exp_ids.size()), 96'd0);
        check(frame_valid == 1'b0, "R9 no report while idle", 96'(frame_valid), 96'd0);
        check(tag_id == last_id, "R5 last identifier held", tag_id, last_id);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule